// File: doc/BRIEF.md
# Byte-Lane Read Parity Checker with Machine-Check Capture

This block checks read data on a wide data bus against one even-parity bit per byte lane. A transfer is checked only in a clock where the ready input is sampled high and the transfer is a read. Lanes whose byte enable is low are left out. A failing transfer produces a one-clock pulse on the parity-status output. That pulse appears in the clock that ends at the second rising edge after the ready edge. The same block also drives an even-parity bit for each lane of write data.

Any error can be recorded for later inspection. A parity error seen while the parity-enable input is high, or any assertion of the bus-check input, copies the address and control of the cycle into a machine-check record. The record keeps its first value until software clears it. If the machine-check enable input is high when the record is taken, the block raises a one-clock exception request once the cycle's final transfer has been seen.

A small state machine owns the record. Its states are `MC_EMPTY` (no record), `MC_ARMED` (record taken, waiting for the end of the cycle), `MC_RAISE` (exception request high for one clock) and `MC_HELD` (record kept, no request). Its transitions are:
- *take-quiet*: `MC_EMPTY`→`MC_HELD` when a record is taken with the enable low.
- *take-wait*: `MC_EMPTY`→`MC_ARMED` when a record is taken with the enable high before the last transfer.
- *take-raise*: `MC_EMPTY`→`MC_RAISE` when a record is taken with the enable high on the last transfer.
- *cycle-end*: `MC_ARMED`→`MC_RAISE`.
- *settle*: `MC_RAISE`→`MC_HELD`.
- *wipe*: any state→`MC_EMPTY` on clear.

Top module: `lane_parity_guard`

## Requirements
- R1: `wr_par_o[n]` is the XOR of write-data lane n, where lane n is bits n*LANE_W to n*LANE_W+LANE_W-1. Each lane together with its bit therefore has even parity.
- R2: A read transfer fails when some enabled lane n has odd parity over read-data lane n and `rd_par_i[n]`. Lane n uses the same bit positions as in R1.
- R3: A lane whose `byte_en_i` bit is 0 never causes a failure, whatever its data and parity.
- R4: No check is made in a clock where `rdy_i` is 0 or `rd_cycle_i` is 0 (a write). Such a clock never produces a `par_err_o` pulse.
- R5: For a failing transfer sampled at rising edge k, `par_err_o` is high from edge k+1 to edge k+2, one clock per failing transfer, and low otherwise.
- R6: A failing transfer with `par_en_i` high at its ready edge k fills the record with that edge's `cyc_addr_i` and `cyc_ctrl_i`, and `mc_valid_o` is high from edge k+1. The same failure with `par_en_i` low leaves the record empty.
- R7: `bus_chk_i` high at edge k fills the record with that edge's address and control, with `mc_valid_o` high from edge k+1.
- R8: While `mc_valid_o` is high, later parity errors and bus-check events do not change `mc_addr_o` or `mc_ctrl_o`.
- R9: `mc_clear_i` high at an edge empties the record (`mc_valid_o` low after it), even if a record would have been taken at that edge.
- R10: If `mce_en_i` is high when a record is taken, `mce_req_o` pulses for one clock. The pulse comes at the same delay after the cycle's final transfer (`rdy_i` and `cyc_last_i` high) as `par_err_o` would. It coincides with `par_err_o` when the failure is on the final transfer. If `mce_en_i` is low at that moment, no pulse follows.
- R11: During and right after reset, `par_err_o`, `mc_valid_o` and `mce_req_o` are 0 and `mc_addr_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_data_i | input | LANES*LANE_W | Read data |
| rd_par_i | input | LANES | Read parity, one bit per lane |
| byte_en_i | input | LANES | Lane enables |
| rdy_i | input | 1 | Transfer ready sample |
| rd_cycle_i | input | 1 | High when the transfer is a read |
| cyc_last_i | input | 1 | High on the final transfer of a bus cycle |
| cyc_addr_i | input | ADDR_W | Address of the current cycle |
| cyc_ctrl_i | input | CTRL_W | Control/type of the current cycle |
| par_en_i | input | 1 | Record parity errors when high |
| bus_chk_i | input | 1 | External bus-error report |
| mce_en_i | input | 1 | Machine-check exception enable |
| mc_clear_i | input | 1 | Empties the record |
| wr_data_i | input | LANES*LANE_W | Write data to protect |
| wr_par_o | output | LANES | Generated write parity |
| par_err_o | output | 1 | Parity-status pulse |
| mc_valid_o | output | 1 | Record holds a value |
| mc_addr_o | output | ADDR_W | Recorded address |
| mc_ctrl_o | output | CTRL_W | Recorded control |
| mce_req_o | output | 1 | Exception request pulse |

## Verification
The bench builds the block with two lanes of four bits, an 8-bit address and a 2-bit control field. With that size, every combination of read data, parity bits and lane enables (4096 cases) can be pushed through back-to-back, and every write-data value can be checked. The expected status is worked out with XOR arithmetic and compared two edges later. A further sweep over ready and read-type states covers the gating of R4. The small address width leaves room for directed sequences through every state-machine transition: first-record retention, clear against a simultaneous capture, and the exception pulse both on and before the final transfer.

// File: rtl/lpg_pkg.sv
package lpg_pkg;
    typedef enum logic [1:0] {
        MC_EMPTY = 2'd0,
        MC_ARMED = 2'd1,
        MC_RAISE = 2'd2,
        MC_HELD  = 2'd3
    } mc_state_e;
endpackage

// File: rtl/lpg_lane_parity.sv
module lpg_lane_parity #(
    parameter int LANES  = 8,
    parameter int LANE_W = 8,
    localparam int DW    = LANES * LANE_W
) (
    input  logic [DW-1:0]    rd_data,
    input  logic [LANES-1:0] rd_par,
    input  logic [LANES-1:0] byte_en,
    input  logic [DW-1:0]    wr_data,
    output logic [LANES-1:0] lane_bad,
    output logic [LANES-1:0] wr_par
);
    for (genvar n = 0; n < LANES; n++) begin : g_lane
        // odd weight over lane plus its bit, counted only when enabled
        assign lane_bad[n] = byte_en[n] & (^{rd_data[n*LANE_W +: LANE_W], rd_par[n]});
        assign wr_par[n]   = ^wr_data[n*LANE_W +: LANE_W];
    end
endmodule

// File: rtl/lpg_sense_stage.sv
module lpg_sense_stage #(
    parameter int LANES  = 8,
    parameter int ADDR_W = 32,
    parameter int CTRL_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LANES-1:0]  lane_bad,
    input  logic [LANES-1:0]  byte_en,
    input  logic              rdy,
    input  logic              rd_cycle,
    input  logic              cyc_last,
    input  logic              par_en,
    input  logic              bus_chk,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CTRL_W-1:0] ctrl,
    output logic              capture,
    output logic              cyc_end,
    output logic [ADDR_W-1:0] s1_addr,
    output logic [CTRL_W-1:0] s1_ctrl,
    output logic              par_err
);
    logic s1_perr;
    logic s1_pen;
    logic s1_bchk;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_perr <= 1'b0;
            s1_pen  <= 1'b0;
            s1_bchk <= 1'b0;
            cyc_end <= 1'b0;
            s1_addr <= '0;
            s1_ctrl <= '0;
            par_err <= 1'b0;
        end else begin
            s1_perr <= rdy && rd_cycle && (|lane_bad);
            s1_pen  <= par_en;
            s1_bchk <= bus_chk;
            cyc_end <= rdy && cyc_last;
            s1_addr <= addr;
            s1_ctrl <= ctrl;
            par_err <= s1_perr;
        end
    end

    assign capture = (s1_perr && s1_pen) || s1_bchk;

    // R4 R5
    property p_err_from_read;
        @(posedge clk) disable iff (!rst_n) par_err |-> $past(rdy && rd_cycle, 2);
    endproperty
    err_needs_read_chk: assert property (p_err_from_read);

    // R3
    property p_err_needs_lane;
        @(posedge clk) disable iff (!rst_n) par_err |-> ($past(byte_en, 2) != '0);
    endproperty
    err_needs_lane_chk: assert property (p_err_needs_lane);
endmodule

// File: rtl/lpg_mc_fsm.sv
module lpg_mc_fsm
    import lpg_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CTRL_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic              cyc_end,
    input  logic              mce_en,
    input  logic              clear,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CTRL_W-1:0] ctrl,
    output logic              mc_valid,
    output logic [ADDR_W-1:0] mc_addr,
    output logic [CTRL_W-1:0] mc_ctrl,
    output logic              mce_req
);
    mc_state_e state, state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= MC_EMPTY;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            MC_EMPTY: begin
                if (capture) begin
                    if (!mce_en)      state_nx = MC_HELD;
                    else if (cyc_end) state_nx = MC_RAISE;
                    else              state_nx = MC_ARMED;
                end
            end
            MC_ARMED: if (cyc_end) state_nx = MC_RAISE;
            MC_RAISE: state_nx = MC_HELD;
            MC_HELD:  state_nx = MC_HELD;
            default:  state_nx = MC_EMPTY;
        endcase
        if (clear) state_nx = MC_EMPTY;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mc_addr <= '0;
            mc_ctrl <= '0;
        end else if (state == MC_EMPTY && capture && !clear) begin
            mc_addr <= addr;
            mc_ctrl <= ctrl;
        end
    end

    always_comb begin
        mc_valid = (state != MC_EMPTY);
        mce_req  = (state == MC_RAISE);
    end

    // R8
    property p_record_kept;
        @(posedge clk) disable iff (!rst_n)
            (mc_valid && $past(mc_valid)) |-> ($stable(mc_addr) && $stable(mc_ctrl));
    endproperty
    record_kept_chk: assert property (p_record_kept);

    // R9
    property p_clear_empties;
        @(posedge clk) disable iff (!rst_n) clear |=> !mc_valid;
    endproperty
    clear_empties_chk: assert property (p_clear_empties);

    // R10
    property p_req_single;
        @(posedge clk) disable iff (!rst_n) mce_req |=> !mce_req;
    endproperty
    req_single_chk: assert property (p_req_single);
endmodule

// File: rtl/lane_parity_guard.sv
module lane_parity_guard #(
    parameter int LANES  = 8,
    parameter int LANE_W = 8,
    parameter int ADDR_W = 32,
    parameter int CTRL_W = 4,
    localparam int DW    = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DW-1:0]     rd_data_i,
    input  logic [LANES-1:0]  rd_par_i,
    input  logic [LANES-1:0]  byte_en_i,
    input  logic              rdy_i,
    input  logic              rd_cycle_i,
    input  logic              cyc_last_i,
    input  logic [ADDR_W-1:0] cyc_addr_i,
    input  logic [CTRL_W-1:0] cyc_ctrl_i,
    input  logic              par_en_i,
    input  logic              bus_chk_i,
    input  logic              mce_en_i,
    input  logic              mc_clear_i,
    input  logic [DW-1:0]     wr_data_i,
    output logic [LANES-1:0]  wr_par_o,
    output logic              par_err_o,
    output logic              mc_valid_o,
    output logic [ADDR_W-1:0] mc_addr_o,
    output logic [CTRL_W-1:0] mc_ctrl_o,
    output logic              mce_req_o
);
    logic [LANES-1:0]  lane_bad;
    logic              capture;
    logic              cyc_end;
    logic [ADDR_W-1:0] s1_addr;
    logic [CTRL_W-1:0] s1_ctrl;

    lpg_lane_parity #(.LANES(LANES), .LANE_W(LANE_W)) u_lanes (
        .rd_data (rd_data_i),
        .rd_par  (rd_par_i),
        .byte_en (byte_en_i),
        .wr_data (wr_data_i),
        .lane_bad(lane_bad),
        .wr_par  (wr_par_o)
    );

    lpg_sense_stage #(.LANES(LANES), .ADDR_W(ADDR_W), .CTRL_W(CTRL_W)) u_sense (
        .clk     (clk),
        .rst_n   (rst_n),
        .lane_bad(lane_bad),
        .byte_en (byte_en_i),
        .rdy     (rdy_i),
        .rd_cycle(rd_cycle_i),
        .cyc_last(cyc_last_i),
        .par_en  (par_en_i),
        .bus_chk (bus_chk_i),
        .addr    (cyc_addr_i),
        .ctrl    (cyc_ctrl_i),
        .capture (capture),
        .cyc_end (cyc_end),
        .s1_addr (s1_addr),
        .s1_ctrl (s1_ctrl),
        .par_err (par_err_o)
    );

    lpg_mc_fsm #(.ADDR_W(ADDR_W), .CTRL_W(CTRL_W)) u_mc (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (capture),
        .cyc_end (cyc_end),
        .mce_en  (mce_en_i),
        .clear   (mc_clear_i),
        .addr    (s1_addr),
        .ctrl    (s1_ctrl),
        .mc_valid(mc_valid_o),
        .mc_addr (mc_addr_o),
        .mc_ctrl (mc_ctrl_o),
        .mce_req (mce_req_o)
    );
endmodule

// File: tb/tb_lane_parity_guard.sv
module tb_lane_parity_guard;
    localparam int LANES = 2, LANE_W = 4, ADDR_W = 8, CTRL_W = 2;
    localparam int DW = LANES * LANE_W;

    logic clk = 1'b0;
    logic rst_n;
    logic [DW-1:0] rd_data, wr_data;
    logic [LANES-1:0] rd_par, byte_en, wr_par;
    logic rdy, rd_cycle, cyc_last, par_en, bus_chk, mce_en, mc_clear;
    logic [ADDR_W-1:0] cyc_addr, mc_addr;
    logic [CTRL_W-1:0] cyc_ctrl, mc_ctrl;
    logic par_err, mc_valid, mce_req;

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;
    bit hist0 = 1'b0, hist1 = 1'b0;

    always #2 clk = ~clk;

    lane_parity_guard #(.LANES(LANES), .LANE_W(LANE_W), .ADDR_W(ADDR_W), .CTRL_W(CTRL_W)) dut (
        .clk(clk), .rst_n(rst_n), .rd_data_i(rd_data), .rd_par_i(rd_par), .byte_en_i(byte_en),
        .rdy_i(rdy), .rd_cycle_i(rd_cycle), .cyc_last_i(cyc_last), .cyc_addr_i(cyc_addr),
        .cyc_ctrl_i(cyc_ctrl), .par_en_i(par_en), .bus_chk_i(bus_chk), .mce_en_i(mce_en),
        .mc_clear_i(mc_clear), .wr_data_i(wr_data), .wr_par_o(wr_par), .par_err_o(par_err),
        .mc_valid_o(mc_valid), .mc_addr_o(mc_addr), .mc_ctrl_o(mc_ctrl), .mce_req_o(mce_req)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        rdy = 0; rd_cycle = 0; cyc_last = 0; par_en = 0; bus_chk = 0; mc_clear = 0;
        byte_en = '0; rd_data = '0; rd_par = '0;
    endtask

    // one read transfer with lane 0 bad, all lanes enabled
    task automatic bad_read(input logic [ADDR_W-1:0] a, input logic [CTRL_W-1:0] c,
                            input logic pe, input logic last);
        rdy = 1; rd_cycle = 1; byte_en = '1; rd_data = 8'h01; rd_par = 2'b00;
        cyc_addr = a; cyc_ctrl = c; par_en = pe; cyc_last = last;
    endtask

    function automatic bit exp_err(input logic [11:0] v);
        bit l0, l1;
        l0 = v[10] & (^{v[3:0], v[8]});
        l1 = v[11] & (^{v[7:4], v[9]});
        return l0 | l1;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        rst_n = 0; idle(); mce_en = 0; cyc_addr = '0; cyc_ctrl = '0; wr_data = '0;
        repeat (3) step();
        // R11 reset values
        check("R11 par_err", par_err, 0);
        check("R11 mc_valid", mc_valid, 0);
        check("R11 mce_req", mce_req, 0);
        check("R11 mc_addr", mc_addr, 0);
        rst_n = 1;
        step();
        check("R11 after release", {par_err, mc_valid, mce_req}, 0);

        // R1 write parity, every write value
        for (int w = 0; w < 256; w++) begin
            wr_data = 8'(w);
            #1;
            check("R1 wr_par", wr_par, {^wr_data[7:4], ^wr_data[3:0]});
        end

        // R2 R3 R5 exhaustive back-to-back read sweep
        hist0 = 0; hist1 = 0;
        for (int i = 0; i < 4096 + 2; i++) begin
            logic [11:0] v;
            check("R2/R3/R5 par_err", par_err, int'(hist1));
            hist1 = hist0;
            if (i < 4096) begin
                v = 12'(i);
                rdy = 1; rd_cycle = 1; rd_data = v[7:0]; rd_par = v[9:8]; byte_en = v[11:10];
                hist0 = exp_err(v);
            end else begin
                idle(); hist0 = 0;
            end
            step();
        end
        check("R6 no record with par_en low", mc_valid, 0);

        // R4 gating sweep: bad data on all lanes, rdy/rd_cycle toggled
        hist0 = 0; hist1 = 0;
        for (int i = 0; i < 34; i++) begin
            check("R4 par_err gating", par_err, int'(hist1));
            hist1 = hist0;
            if (i < 32) begin
                rdy = i[0]; rd_cycle = i[1]; byte_en = '1; rd_data = 8'h11; rd_par = 2'b00;
                hist0 = i[0] & i[1];
            end else begin
                idle(); hist0 = 0;
            end
            step();
        end

        // R6 capture with par_en, mce off
        bad_read(8'h5A, 2'd2, 1'b1, 1'b1);
        step(); idle(); step();
        check("R6 mc_valid", mc_valid, 1);
        check("R6 mc_addr", mc_addr, 8'h5A);
        check("R6 mc_ctrl", mc_ctrl, 2);
        check("R10 no req with mce off", mce_req, 0);
        step();
        check("R10 no late req", mce_req, 0);

        // R8 later events do not overwrite
        bus_chk = 1; cyc_addr = 8'h33; cyc_ctrl = 2'd1;
        step();
        bad_read(8'h44, 2'd3, 1'b1, 1'b0);
        step(); idle(); step(); step();
        check("R8 addr kept", mc_addr, 8'h5A);
        check("R8 ctrl kept", mc_ctrl, 2);

        // R9 clear
        mc_clear = 1; step(); mc_clear = 0;
        check("R9 cleared", mc_valid, 0);

        // R9 clear wins over simultaneous capture
        bus_chk = 1; cyc_addr = 8'h77; step();
        bus_chk = 0; mc_clear = 1; step(); mc_clear = 0;
        check("R9 clear beats capture", mc_valid, 0);
        step();
        check("R9 stays empty", mc_valid, 0);

        // R7 bus check capture
        bus_chk = 1; cyc_addr = 8'h33; cyc_ctrl = 2'd1; step();
        bus_chk = 0; cyc_addr = 8'h00; step();
        check("R7 mc_valid", mc_valid, 1);
        check("R7 mc_addr", mc_addr, 8'h33);
        check("R7 mc_ctrl", mc_ctrl, 1);
        mc_clear = 1; step(); mc_clear = 0;

        // R10 error before last transfer, request after last one
        mce_en = 1;
        bad_read(8'h10, 2'd0, 1'b1, 1'b0);
        step();
        rdy = 1; rd_cycle = 1; byte_en = '1; rd_data = '0; rd_par = '0;
        cyc_addr = 8'h11; cyc_last = 1; par_en = 1;
        step(); idle();
        check("R10 armed valid", mc_valid, 1);
        check("R10 not yet", mce_req, 0);
        step();
        check("R10 req after last", mce_req, 1);
        check("R10 last transfer clean", par_err, 0);
        step();
        check("R10 req one clock", mce_req, 0);
        check("R10 addr of failing transfer", mc_addr, 8'h10);
        mc_clear = 1; step(); mc_clear = 0;

        // R10 error on last transfer: request aligned with par_err
        bad_read(8'h20, 2'd1, 1'b1, 1'b1);
        step(); idle(); step();
        check("R10 aligned req", mce_req, 1);
        check("R5 aligned err", par_err, 1);
        step();
        check("R10 req dropped", mce_req, 0);
        check("R5 err one clock", par_err, 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule